// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block turns a compact memory-operand descriptor into an effective address. The descriptor names an optional base register and an optional index register, a two-bit scale code, a displacement and its length, and the address mode. The block drives the two register selects onto a combinational read port and takes the register values back in the same cycle. It gates off absent terms, scales the index, sign-extends the displacement and adds the three terms in one adder path. The result is registered.

Two address modes are supported. In the wide mode the address is the full port width, the index may be multiplied by 1, 2, 4 or 8, and the displacement is either 8 bits or full width. In the narrow mode the address is 16 bits, zero-extended on the output. The index is never scaled in this mode, and a descriptor that asks for a scale there is flagged as illegal. The displacement is either 8 or 16 bits.

Every accepted request produces a one-cycle result strobe on the following clock. Between strobes the result and the flag hold their last value.

Top module: `ea_gen`

## Requirements
- R1: In wide mode (`mode_wide`=1), `ea_out` = base + (index × scale factor) + sign-extended displacement, modulo 2^32.
- R2: The scale code `scale` selects the factor as 2'b00 = ×1, 2'b01 = ×2, 2'b10 = ×4, 2'b11 = ×8, applied to the index term only.
- R3: With `disp_long`=0 the displacement is `disp[7:0]` sign-extended, and `disp[31:8]` has no effect on the result.
- R4: With `disp_long`=1 in wide mode, all 32 bits of `disp` are used as a signed displacement.
- R5: In narrow mode (`mode_wide`=0), `disp_long`=1 uses `disp[15:0]` sign-extended. The sum wraps modulo 2^16 and `ea_out[31:16]` is zero.
- R6: In narrow mode the index is added unscaled. `ea_illegal` is 1 with the result when `scale` is nonzero in narrow mode, and 0 otherwise (always 0 in wide mode).
- R7: A term whose enable (`base_en` or `idx_en`) is 0 contributes zero, whatever its select and its register value.
- R8: `rd_sel_a` follows `base_sel` and `rd_sel_b` follows `idx_sel` in the same cycle, and the result uses `rd_val_a` as the base and `rd_val_b` as the index.
- R9: `ea_valid` is 1 in exactly the cycle after each cycle with `req_valid`=1. Back-to-back requests give back-to-back results. `ea_out` and `ea_illegal` hold while no request is accepted.
- R10: While `rst` is high, `ea_valid`, `ea_out` and `ea_illegal` are cleared to zero on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Descriptor on the inputs is to be processed this cycle |
| mode_wide | input | 1 | 1 = 32-bit address mode, 0 = 16-bit address mode |
| base_en | input | 1 | Base term present |
| base_sel | input | 3 | Base register select |
| idx_en | input | 1 | Index term present |
| idx_sel | input | 3 | Index register select |
| scale | input | 2 | Index scale code |
| disp_long | input | 1 | 0 = 8-bit displacement, 1 = mode-width displacement |
| disp | input | 32 | Displacement field |
| rd_sel_a | output | 3 | Register read select for the base value |
| rd_val_a | input | 32 | Register value returned for `rd_sel_a` |
| rd_sel_b | output | 3 | Register read select for the index value |
| rd_val_b | input | 32 | Register value returned for `rd_sel_b` |
| ea_valid | output | 1 | Result strobe, one cycle after the request |
| ea_out | output | 32 | Effective address |
| ea_illegal | output | 1 | Scale requested in 16-bit mode |

## Verification
The illegal-scale flag and the 16-bit wraparound can fall in the same cycle. In that case the flag must rise while the address is still formed from the unscaled index, truncated to 16 bits. The bench provokes this with a narrow-mode request that has a nonzero scale code and operands whose sum passes 0xFFFF. It judges the result by requiring the flag set, the upper half zero, and the low half equal to the unscaled sum modulo 2^16. A scaled result, or a carry leaking into bit 16, would then show at the ports.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    localparam int SEL_W    = 3;
    localparam int NARROW_W = 16;
    localparam int SHORT_W  = 8;

    typedef enum logic [1:0] {
        SC_X1 = 2'b00,
        SC_X2 = 2'b01,
        SC_X4 = 2'b10,
        SC_X8 = 2'b11
    } scale_e;

    typedef struct packed {
        logic             wide;
        logic             base_on;
        logic [SEL_W-1:0] base_sel;
        logic             idx_on;
        logic [SEL_W-1:0] idx_sel;
        scale_e           scale;
        logic             disp_long;
    } desc_t;

    // Shift applied to the index: scaling only exists in wide mode.
    function automatic logic [1:0] eff_shift(input logic wide, input scale_e s);
        return wide ? logic'(1'b1) ? s : 2'b00 : 2'b00;
    endfunction

    function automatic logic scale_forbidden(input logic wide, input scale_e s);
        return !wide && (s != SC_X1);
    endfunction

endpackage

// File: rtl/ea_term_gate.sv
module ea_term_gate #(
    parameter int AW = 32
) (
    input  logic          en,
    input  logic [AW-1:0] value,
    output logic [AW-1:0] term
);
    always_comb begin
        term = en ? value : '0;
    end
endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
    import ea_gen_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          wide,
    input  logic          disp_long,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] disp_ext
);
    localparam int PAD_S = AW - SHORT_W;
    localparam int PAD_N = AW - NARROW_W;

    logic [AW-1:0] ext_short;
    logic [AW-1:0] ext_narrow;

    always_comb begin
        ext_short  = {{PAD_S{disp[SHORT_W-1]}},  disp[SHORT_W-1:0]};
        ext_narrow = {{PAD_N{disp[NARROW_W-1]}}, disp[NARROW_W-1:0]};
        if (!disp_long)
            disp_ext = ext_short;
        else if (wide)
            disp_ext = disp;
        else
            disp_ext = ext_narrow;
    end
endmodule

// File: rtl/ea_scaler.sv
module ea_scaler
    import ea_gen_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          wide,
    input  scale_e        scale,
    input  logic [AW-1:0] index,
    output logic [AW-1:0] scaled
);
    logic [1:0] sh;

    always_comb begin
        sh     = eff_shift(wide, scale);
        scaled = index << sh;
    end
endmodule

// File: rtl/ea_sum_reg.sv
module ea_sum_reg
    import ea_gen_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          wide,
    input  logic          bad_scale,
    input  logic [AW-1:0] base_t,
    input  logic [AW-1:0] index_t,
    input  logic [AW-1:0] disp_t,
    output logic          res_valid,
    output logic [AW-1:0] res_addr,
    output logic          res_bad
);
    localparam int PAD_N = AW - NARROW_W;

    logic [AW-1:0] sum;
    logic [AW-1:0] sized;

    always_comb begin
        sum   = base_t + index_t + disp_t;
        sized = wide ? sum : {{PAD_N{1'b0}}, sum[NARROW_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_addr  <= '0;
            res_bad   <= 1'b0;
        end else begin
            res_valid <= take;
            if (take) begin
                res_addr <= sized;
                res_bad  <= bad_scale;
            end
        end
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             mode_wide,
    input  logic             base_en,
    input  logic [SEL_W-1:0] base_sel,
    input  logic             idx_en,
    input  logic [SEL_W-1:0] idx_sel,
    input  logic [1:0]       scale,
    input  logic             disp_long,
    input  logic [AW-1:0]    disp,
    output logic [SEL_W-1:0] rd_sel_a,
    input  logic [AW-1:0]    rd_val_a,
    output logic [SEL_W-1:0] rd_sel_b,
    input  logic [AW-1:0]    rd_val_b,
    output logic             ea_valid,
    output logic [AW-1:0]    ea_out,
    output logic             ea_illegal
);
    localparam int NTERM = 2;

    desc_t         desc;
    logic          term_en  [NTERM];
    logic [AW-1:0] term_raw [NTERM];
    logic [AW-1:0] term_val [NTERM];
    logic [AW-1:0] idx_scaled;
    logic [AW-1:0] disp_x;
    logic          bad;

    always_comb begin
        desc.wide      = mode_wide;
        desc.base_on   = base_en;
        desc.base_sel  = base_sel;
        desc.idx_on    = idx_en;
        desc.idx_sel   = idx_sel;
        desc.scale     = scale_e'(scale);
        desc.disp_long = disp_long;
    end

    assign rd_sel_a    = desc.base_sel;
    assign rd_sel_b    = desc.idx_sel;
    assign term_en[0]  = desc.base_on;
    assign term_en[1]  = desc.idx_on;
    assign term_raw[0] = rd_val_a;
    assign term_raw[1] = rd_val_b;
    assign bad         = scale_forbidden(desc.wide, desc.scale);

    for (genvar g = 0; g < NTERM; g++) begin : g_term
        ea_term_gate #(.AW(AW)) u_gate (
            .en    (term_en[g]),
            .value (term_raw[g]),
            .term  (term_val[g])
        );
    end

    ea_scaler #(.AW(AW)) u_scale (
        .wide   (desc.wide),
        .scale  (desc.scale),
        .index  (term_val[1]),
        .scaled (idx_scaled)
    );

    ea_disp_ext #(.AW(AW)) u_disp (
        .wide      (desc.wide),
        .disp_long (desc.disp_long),
        .disp      (disp),
        .disp_ext  (disp_x)
    );

    ea_sum_reg #(.AW(AW)) u_sum (
        .clk       (clk),
        .rst       (rst),
        .take      (req_valid),
        .wide      (desc.wide),
        .bad_scale (bad),
        .base_t    (term_val[0]),
        .index_t   (idx_scaled),
        .disp_t    (disp_x),
        .res_valid (ea_valid),
        .res_addr  (ea_out),
        .res_bad   (ea_illegal)
    );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          mode_wide,
    input logic [1:0]    scale,
    input logic          ea_valid,
    input logic [AW-1:0] ea_out,
    input logic          ea_illegal
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ea_valid);                                              // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !ea_valid);                                            // R9
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(ea_out) && $stable(ea_illegal)));             // R9
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mode_wide) |=> (ea_out[AW-1:16] == '0));               // R5
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (ea_illegal == (!$past(mode_wide) && ($past(scale) != 2'b00)))); // R6
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .mode_wide  (mode_wide),
    .scale      (scale),
    .ea_valid   (ea_valid),
    .ea_out     (ea_out),
    .ea_illegal (ea_illegal)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, mode_wide, base_en, idx_en, disp_long;
    logic [2:0]  base_sel, idx_sel, rd_sel_a, rd_sel_b;
    logic [1:0]  scale;
    logic [31:0] disp, rd_val_a, rd_val_b, ea_out;
    logic        ea_valid, ea_illegal;
    logic [31:0] rf [8];
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    assign rd_val_a = rf[rd_sel_a];
    assign rd_val_b = rf[rd_sel_b];

    ea_gen dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic w, input logic be, input logic [2:0] bs,
            input logic ie, input logic [2:0] is, input logic [1:0] sc, input logic dl, input logic [31:0] d);
        logic [31:0] b, i, x, s;
        b = be ? rf[bs] : 32'h0;
        i = ie ? rf[is] : 32'h0;
        if (w) i = i * (32'd1 << sc);
        if (!dl)    x = {{24{d[7]}}, d[7:0]};
        else if (w) x = d;
        else        x = {{16{d[15]}}, d[15:0]};
        s = b + i + x;
        if (!w) s = {16'h0, s[15:0]};
        return s;
    endfunction

    task automatic put(input logic w, input logic be, input logic [2:0] bs, input logic ie,
            input logic [2:0] is, input logic [1:0] sc, input logic dl, input logic [31:0] d);
        req_valid = 1; mode_wide = w; base_en = be; base_sel = bs;
        idx_en = ie; idx_sel = is; scale = sc; disp_long = dl; disp = d;
    endtask

    // One request, result checked on the next cycle, hold checked on the one after.
    task automatic issue(input string req, input logic w, input logic be, input logic [2:0] bs,
            input logic ie, input logic [2:0] is, input logic [1:0] sc, input logic dl, input logic [31:0] d);
        logic [31:0] exp;
        logic        expbad;
        @(negedge clk);
        put(w, be, bs, ie, is, sc, dl, d);
        exp    = model(w, be, bs, ie, is, sc, dl, d);
        expbad = !w && (sc != 2'b00);
        @(negedge clk);
        req_valid = 0; disp = ~d; scale = ~sc;
        chk(ea_valid == 1'b1, {req, " valid"}, {31'h0, ea_valid}, 32'h1);
        chk(ea_out == exp, {req, " addr"}, ea_out, exp);
        chk(ea_illegal == expbad, {req, " illegal"}, {31'h0, ea_illegal}, {31'h0, expbad});
        @(negedge clk);
        chk(ea_valid == 1'b0 && ea_out == exp, "R9 hold", ea_out, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ea_valid == 0, "R10 valid", {31'h0, ea_valid}, 0);
        chk(ea_out == 0, "R10 addr", ea_out, 0);
        chk(ea_illegal == 0, "R10 illegal", {31'h0, ea_illegal}, 0);
    endtask

    task automatic t_scale();
        for (int s = 0; s < 4; s++)
            issue("R2 R1 scale", 1, 1, 3'd1, 1, 3'd2, 2'(s), 0, 32'h0000_0010);
        issue("R1 wrap32", 1, 1, 3'd7, 1, 3'd6, 2'd3, 1, 32'h8000_0000);
    endtask

    task automatic t_disp_short();
        issue("R3 short neg", 1, 1, 3'd1, 0, 3'd0, 2'd0, 0, 32'h1234_56F0);
        issue("R3 short pos", 0, 1, 3'd1, 0, 3'd0, 2'd0, 0, 32'hFFFF_FF7F);
    endtask

    task automatic t_disp_long32();
        issue("R4 long", 1, 1, 3'd3, 1, 3'd4, 2'd2, 1, 32'hFFF0_0000);
    endtask

    task automatic t_mode16();
        issue("R5 narrow wrap", 0, 1, 3'd5, 1, 3'd3, 2'd0, 1, 32'hABCD_8001);
    endtask

    task automatic t_illegal();
        issue("R6 narrow scale", 0, 1, 3'd5, 1, 3'd3, 2'd3, 1, 32'h0000_7000);
        issue("R6 wide no flag", 1, 1, 3'd5, 1, 3'd3, 2'd3, 0, 32'h0);
    endtask

    task automatic t_disabled();
        issue("R7 no base", 1, 0, 3'd7, 1, 3'd1, 2'd1, 0, 32'h4);
        issue("R7 no index", 1, 1, 3'd1, 0, 3'd7, 2'd3, 0, 32'h4);
        issue("R7 none", 1, 0, 3'd6, 0, 3'd7, 2'd2, 1, 32'h0000_1000);
    endtask

    task automatic t_readport();
        @(negedge clk);
        put(1, 1, 3'd5, 1, 3'd2, 2'd0, 0, 32'h0);
        req_valid = 0;
        #1;
        chk(rd_sel_a == 3'd5, "R8 sel a", {29'h0, rd_sel_a}, 5);
        chk(rd_sel_b == 3'd2, "R8 sel b", {29'h0, rd_sel_b}, 2);
        issue("R8 operands", 1, 1, 3'd2, 1, 3'd5, 2'd0, 0, 32'h0);
    endtask

    task automatic t_backtoback();
        logic [31:0] e0, e1, e2;
        @(negedge clk);
        put(1, 1, 3'd1, 0, 3'd0, 2'd0, 0, 32'h1);
        e0 = model(1, 1, 3'd1, 0, 3'd0, 2'd0, 0, 32'h1);
        @(negedge clk);
        chk(ea_valid && ea_out == e0, "R9 b2b 0", ea_out, e0);
        put(0, 1, 3'd2, 1, 3'd3, 2'd0, 0, 32'h2);
        e1 = model(0, 1, 3'd2, 1, 3'd3, 2'd0, 0, 32'h2);
        @(negedge clk);
        chk(ea_valid && ea_out == e1, "R9 b2b 1", ea_out, e1);
        put(1, 0, 3'd0, 1, 3'd4, 2'd1, 1, 32'h100);
        e2 = model(1, 0, 3'd0, 1, 3'd4, 2'd1, 1, 32'h100);
        @(negedge clk);
        chk(ea_valid && ea_out == e2, "R9 b2b 2", ea_out, e2);
        req_valid = 0;
        @(negedge clk);
        chk(!ea_valid, "R9 b2b end", {31'h0, ea_valid}, 0);
    endtask

    initial begin
        rf[0] = 32'h0000_0100; rf[1] = 32'h0000_1000; rf[2] = 32'h0000_0020;
        rf[3] = 32'h0001_8003; rf[4] = 32'h0000_0400; rf[5] = 32'h1234_F00F;
        rf[6] = 32'h2000_0001; rf[7] = 32'hF000_0000;
        put(0, 0, 0, 0, 0, 0, 0, 0);
        req_valid = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_scale();
        t_disp_short();
        t_disp_long32();
        t_mode16();
        t_illegal();
        t_disabled();
        t_readport();
        t_backtoback();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule